// File: doc/BRIEF.md
# Sample-Stream Link Framer

This block takes a continuous stream of 96-bit digitised sample words in one clock domain and sends them over a one-way link as fixed-length synchronous frames. The link is a 64-bit word interface with an 8-bit per-byte control field, in the style of a 10G media-independent interface. The receiver never answers: nothing is acknowledged and nothing is resent. A frame that arrives damaged is discarded downstream. The only check a frame carries is a CRC-32.

Sample words cross from the input clock into the link clock through a small dual-clock FIFO with Gray-coded pointers. The sequencer regroups every two sample words into three link words. It waits for an external frame-sync pulse and starts a frame only once the FIFO holds a whole frame of payload. Each frame contains a start word, a header word, the payload and a CRC word. The header holds a frame counter and one slot of a monitor-and-control virtual channel. The link runs faster than the payload, so idle words fill every cycle that is not part of a frame.

Top module: `sample_framer`

## Requirements
- R1: While either reset is high and after release, until a frame starts, the link presents the idle word: control 8'hFF with data 64'h0707070707070707. The overflow flag reads 0 after reset.
- R2: Every link word outside a frame is the idle word. At least one idle word follows each frame.
- R3: A frame is one start word (control 8'h01, data 64'hD5555555555555FB), then 3*GROUPS+2 words with control 8'h00: the header, 3*GROUPS payload words and the CRC word.
- R4: Header bits [63:48] hold a frame counter. It is 0 in the first frame after reset and rises by one in each later frame.
- R5: Pulsing mc_load stores mc_data as a pending channel slot. The next header then carries length 16'd4 in bits [47:32] and the stored value in bits [31:0]. The slot is used once, so a header with no pending slot carries zero in both fields.
- R6: For each pair of sample words, A then B, the payload words are A[63:0], {B[31:0], A[95:64]} and B[95:32]. Pairs follow the input order, and each frame uses 2*GROUPS sample words.
- R7: The low 32 bits of the CRC word are a CRC-32 over the header and payload words, with the upper 32 bits zero. The CRC uses polynomial 0x04C11DB7, is not reflected, starts at all ones and is inverted at the end. Each 64-bit word is fed in from bit 63 down to bit 0.
- R8: A frame starts only after a frame_sync pulse, which is held pending until it is used. It also needs at least 2*GROUPS sample words in the FIFO. Until both hold, only idle words are sent.
- R9: A sample word offered while the FIFO is full is discarded, and the overflow flag sets and stays set until reset. The words already stored are still sent in order, and no partial frame is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Sample-side clock |
| in_rst | input | 1 | Synchronous active-high reset, sample side |
| in_valid | input | 1 | in_data holds a sample word this cycle |
| in_data | input | 96 | Sample word |
| ovf_err | output | 1 | Sticky FIFO overflow flag (in_clk domain) |
| out_clk | input | 1 | Link clock |
| out_rst | input | 1 | Synchronous active-high reset, link side |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| mc_load | input | 1 | Store mc_data for the next header |
| mc_data | input | 32 | Monitor-and-control channel word |
| out_data | output | 64 | Link data word |
| out_ctrl | output | 8 | Link control field, one bit per byte |

## Verification
A wrong sequencer state shows on out_ctrl at once. A frame body that is too long or too short, a start word with no header after it, or a non-idle word between frames is seen at the first frame boundary. Errors in the read pointer or the regroup hold register show up as misplaced 32-bit halves in the payload of the same frame. Any such error also breaks the CRC word, which comes at the end of that frame. A lost sync or a missed FIFO count shows as idle words running on after both start conditions hold, or as a frame starting early.

// File: rtl/sf_pkg.sv
package sf_pkg;

  localparam int SAMPLE_W = 96;
  localparam int LINK_W   = 64;
  localparam int CTRL_W   = LINK_W / 8;
  localparam int HALF_W   = 32;

  localparam logic [31:0]        CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0]        CRC_SEED  = 32'hFFFFFFFF;
  localparam logic [CTRL_W-1:0]  CTL_IDLE  = 8'hFF;
  localparam logic [CTRL_W-1:0]  CTL_START = 8'h01;
  localparam logic [CTRL_W-1:0]  CTL_DATA  = 8'h00;
  localparam logic [LINK_W-1:0]  IDLE_WORD = {8{8'h07}};
  localparam logic [LINK_W-1:0]  START_WORD = 64'hD5555555555555FB;
  localparam logic [15:0]        VC_BYTES  = 16'd4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_HDR, SQ_PAY, SQ_CRC
  } seq_state_t;

  function automatic logic [31:0] crc_step64(input logic [31:0] c,
                                             input logic [LINK_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = LINK_W - 1; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/sf_cdc_fifo.sv
module sf_cdc_fifo #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wen,
  input  logic [WIDTH-1:0] wdata,
  output logic             ovf,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             ren,
  output logic [WIDTH-1:0] rdata,
  output logic [AW:0]      rcount
);

  logic [WIDTH-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, wbin_nx;
  logic [AW:0] rbin, rgray, rbin_nx;
  logic [AW:0] rg_s1, rg_s2, wg_s1, wg_s2, wsync_bin;
  logic        full, wacc;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;
  assign full    = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign wacc    = wen & ~full;

  // write side
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      ovf   <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wacc) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wen && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wacc) mem[wbin[AW-1:0]] <= wdata;
  end

  // read side
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (ren) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (ren) rdata <= mem[rbin[AW-1:0]];
  end

  always_comb begin
    wsync_bin[AW] = wg_s2[AW];
    for (int i = AW - 1; i >= 0; i--) wsync_bin[i] = wsync_bin[i+1] ^ wg_s2[i];
  end

  assign rcount = wsync_bin - rbin;

endmodule

// File: rtl/sf_crc_acc.sv
module sf_crc_acc
  import sf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              en,
  input  logic [LINK_W-1:0] din,
  output logic [31:0]       crc
);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (en)     crc <= crc_step64(crc, din);
  end

endmodule

// File: rtl/sf_frame_seq.sv
module sf_frame_seq
  import sf_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int CW     = 5,
  localparam int NEED  = 2 * GROUPS,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_sync,
  input  logic                mc_load,
  input  logic [31:0]         mc_data,
  input  logic [CW-1:0]       fifo_count,
  input  logic [SAMPLE_W-1:0] fifo_rdata,
  output logic                fifo_ren,
  input  logic [31:0]         crc_val,
  output logic                crc_init,
  output logic                crc_en,
  output logic [LINK_W-1:0]   crc_din,
  output logic [LINK_W-1:0]   out_data,
  output logic [CTRL_W-1:0]   out_ctrl
);

  seq_state_t        st;
  logic [GW-1:0]     grp;
  logic [1:0]        ph;
  logic [LINK_W-1:0] hold;
  logic [15:0]       fcnt;
  logic              pend, mc_pend, start, enough;
  logic [31:0]       mc_reg;
  logic [LINK_W-1:0] hdr_word, pay_word;

  assign enough   = (fifo_count >= CW'(NEED));
  assign start    = (st == SQ_IDLE) && (pend || frame_sync) && enough;
  assign hdr_word = {fcnt, (mc_pend ? VC_BYTES : 16'd0), (mc_pend ? mc_reg : 32'd0)};

  always_comb begin
    case (ph)
      2'd0:    pay_word = fifo_rdata[LINK_W-1:0];
      2'd1:    pay_word = {fifo_rdata[HALF_W-1:0], hold[HALF_W-1:0]};
      default: pay_word = hold;
    endcase
  end

  always_comb begin
    fifo_ren = (st == SQ_HDR) ||
               ((st == SQ_PAY) && ((ph == 2'd0) || ((ph == 2'd2) && (grp != LAST_GRP))));
    crc_init = (st == SQ_START);
    crc_en   = (st == SQ_HDR) || (st == SQ_PAY);
    crc_din  = (st == SQ_HDR) ? hdr_word : pay_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      grp      <= '0;
      ph       <= 2'd0;
      hold     <= '0;
      fcnt     <= '0;
      pend     <= 1'b0;
      mc_pend  <= 1'b0;
      mc_reg   <= '0;
      out_data <= IDLE_WORD;
      out_ctrl <= CTL_IDLE;
    end else begin
      pend <= (pend | frame_sync) & ~start;
      if (st == SQ_HDR) mc_pend <= mc_load;
      else if (mc_load) mc_pend <= 1'b1;
      if (mc_load) mc_reg <= mc_data;

      case (st)
        SQ_IDLE: begin
          out_data <= IDLE_WORD;
          out_ctrl <= CTL_IDLE;
          if (start) st <= SQ_START;
        end
        SQ_START: begin
          out_data <= START_WORD;
          out_ctrl <= CTL_START;
          st       <= SQ_HDR;
        end
        SQ_HDR: begin
          out_data <= hdr_word;
          out_ctrl <= CTL_DATA;
          ph       <= 2'd0;
          grp      <= '0;
          st       <= SQ_PAY;
        end
        SQ_PAY: begin
          out_data <= pay_word;
          out_ctrl <= CTL_DATA;
          case (ph)
            2'd0: begin
              hold <= {{HALF_W{1'b0}}, fifo_rdata[SAMPLE_W-1:LINK_W]};
              ph   <= 2'd1;
            end
            2'd1: begin
              hold <= fifo_rdata[SAMPLE_W-1:HALF_W];
              ph   <= 2'd2;
            end
            default: begin
              ph <= 2'd0;
              if (grp == LAST_GRP) st <= SQ_CRC;
              else                 grp <= grp + 1'b1;
            end
          endcase
        end
        SQ_CRC: begin
          out_data <= {32'd0, ~crc_val};
          out_ctrl <= CTL_DATA;
          fcnt     <= fcnt + 1'b1;
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sample_framer.sv
module sample_framer
  import sf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int GROUPS     = 4,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                in_clk,
  input  logic                in_rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                ovf_err,
  input  logic                out_clk,
  input  logic                out_rst,
  input  logic                frame_sync,
  input  logic                mc_load,
  input  logic [31:0]         mc_data,
  output logic [LINK_W-1:0]   out_data,
  output logic [CTRL_W-1:0]   out_ctrl
);

  logic [CW-1:0]       fifo_count;
  logic [SAMPLE_W-1:0] fifo_rdata;
  logic                fifo_ren;
  logic [31:0]         crc_val;
  logic                crc_init, crc_en;
  logic [LINK_W-1:0]   crc_din;

  sf_cdc_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk  (in_clk),
    .wrst  (in_rst),
    .wen   (in_valid),
    .wdata (in_data),
    .ovf   (ovf_err),
    .rclk  (out_clk),
    .rrst  (out_rst),
    .ren   (fifo_ren),
    .rdata (fifo_rdata),
    .rcount(fifo_count)
  );

  sf_frame_seq #(.GROUPS(GROUPS), .CW(CW)) u_seq (
    .clk       (out_clk),
    .rst       (out_rst),
    .frame_sync(frame_sync),
    .mc_load   (mc_load),
    .mc_data   (mc_data),
    .fifo_count(fifo_count),
    .fifo_rdata(fifo_rdata),
    .fifo_ren  (fifo_ren),
    .crc_val   (crc_val),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .crc_din   (crc_din),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl)
  );

  sf_crc_acc u_crc (
    .clk (out_clk),
    .rst (out_rst),
    .init(crc_init),
    .en  (crc_en),
    .din (crc_din),
    .crc (crc_val)
  );

endmodule

// File: rtl/sample_framer_chk.sv
module sample_framer_chk #(
  parameter int GROUPS = 4,
  parameter int CW     = 5,
  localparam int BODY  = 3 * GROUPS + 2
) (
  input logic          in_clk,
  input logic          in_rst,
  input logic          out_clk,
  input logic          out_rst,
  input logic          ovf_err,
  input logic [63:0]   out_data,
  input logic [7:0]    out_ctrl,
  input logic          fifo_ren,
  input logic [CW-1:0] fifo_count
);

  logic [7:0] run;

  always_ff @(posedge out_clk) begin
    if (out_rst)                run <= '0;
    else if (out_ctrl == 8'h00) run <= run + 1'b1;
    else                        run <= '0;
  end

  // R2
  ctrl_legal_chk: assert property (@(posedge out_clk) disable iff (out_rst)
    (out_ctrl == 8'hFF) || (out_ctrl == 8'h01) || (out_ctrl == 8'h00));

  // R2
  idle_data_chk: assert property (@(posedge out_clk) disable iff (out_rst)
    (out_ctrl == 8'hFF) |-> (out_data == 64'h0707070707070707));

  // R3
  start_then_hdr_chk: assert property (@(posedge out_clk) disable iff (out_rst)
    (out_ctrl == 8'h01) |=> (out_ctrl == 8'h00));

  // R3
  frame_len_chk: assert property (@(posedge out_clk) disable iff (out_rst)
    ((out_ctrl != 8'h00) && (run != 8'd0)) |-> (run == 8'(BODY)));

  // R9
  ovf_sticky_chk: assert property (@(posedge in_clk) disable iff (in_rst)
    ovf_err |=> ovf_err);

  // R8
  no_empty_read_chk: assert property (@(posedge out_clk) disable iff (out_rst)
    fifo_ren |-> (fifo_count != '0));

endmodule

bind sample_framer sample_framer_chk #(.GROUPS(GROUPS), .CW(CW)) u_chk (
  .in_clk    (in_clk),
  .in_rst    (in_rst),
  .out_clk   (out_clk),
  .out_rst   (out_rst),
  .ovf_err   (ovf_err),
  .out_data  (out_data),
  .out_ctrl  (out_ctrl),
  .fifo_ren  (fifo_ren),
  .fifo_count(fifo_count)
);

// File: tb/sample_framer_bench.sv
`timescale 1ns/1ps
module sample_framer_bench;

  localparam int GROUPS = 4;
  localparam int NWORDS = 2 * GROUPS;
  localparam int NPAY   = 3 * GROUPS;
  localparam logic [63:0] IDLE_W  = 64'h0707070707070707;
  localparam logic [63:0] START_W = 64'hD5555555555555FB;
  // {mc present, mc word, sample seed}
  localparam logic [48:0] VECS [4] = '{
    {1'b1, 32'h1234ABCD, 16'h0101},
    {1'b0, 32'h00000000, 16'h2202},
    {1'b1, 32'hFFFF0000, 16'h3303},
    {1'b1, 32'h00000001, 16'h4404}
  };

  logic        in_clk = 0, out_clk = 0;
  logic        in_rst = 1, out_rst = 1;
  logic        in_valid = 0;
  logic [95:0] in_data = '0;
  logic        frame_sync = 0, mc_load = 0;
  logic [31:0] mc_data = '0;
  logic        ovf_err;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_fcnt = 16'd0;
  logic [95:0] exp_q[$];

  always #4   out_clk = ~out_clk;
  always #5.5 in_clk  = ~in_clk;

  sample_framer #(.FIFO_DEPTH(16), .GROUPS(GROUPS)) u_sample_framer (
    .in_clk(in_clk), .in_rst(in_rst), .in_valid(in_valid), .in_data(in_data),
    .ovf_err(ovf_err), .out_clk(out_clk), .out_rst(out_rst),
    .frame_sync(frame_sync), .mc_load(mc_load), .mc_data(mc_data),
    .out_data(out_data), .out_ctrl(out_ctrl)
  );

  task automatic check(input bit ok, input string req,
                       input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mkword(input logic [15:0] seed, input int i);
    return {seed, 16'(i), ~seed, 16'(i * 7 + 3), seed ^ 16'h3C3C, 16'(i) ^ 16'hA55A};
  endfunction

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [63:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 63; b >= 0; b--) r = (r[31] ^ d[b]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  task automatic push_words(input logic [15:0] seed, input int n, input int first);
    for (int i = 0; i < n; i++) begin
      @(negedge in_clk);
      in_valid = 1;
      in_data  = mkword(seed, first + i);
      if (exp_q.size() < 16) exp_q.push_back(in_data);
    end
    @(negedge in_clk);
    in_valid = 0;
  endtask

  task automatic pulse_sync();
    @(negedge out_clk); frame_sync = 1;
    @(negedge out_clk); frame_sync = 0;
  endtask

  task automatic load_mc(input logic [31:0] d);
    @(negedge out_clk); mc_load = 1; mc_data = d;
    @(negedge out_clk); mc_load = 0;
  endtask

  task automatic idle_window(input int n, input string req);
    bit bad = 0;
    logic [63:0] seen = IDLE_W;
    for (int k = 0; k < n; k++) begin
      @(negedge out_clk);
      if (!(out_ctrl == 8'hFF && out_data == IDLE_W)) begin bad = 1; seen = out_data; end
    end
    check(!bad, req, {32'd0, seen}, {32'd0, IDLE_W});
  endtask

  task automatic capture_frame(input bit has_vc, input logic [31:0] vcd);
    logic [63:0] w [NPAY + 2];
    logic [63:0] ep [NPAY];
    logic [95:0] a, b;
    logic [31:0] crc;
    bit bad_idle = 0, bad_ctrl = 0, bad_pay = 0;
    int waited = 0, bad_k = 0;
    @(negedge out_clk);
    while (out_ctrl != 8'h01 && waited < 3000) begin
      if (!(out_ctrl == 8'hFF && out_data == IDLE_W)) bad_idle = 1;
      @(negedge out_clk);
      waited++;
    end
    check(!bad_idle, "R2 idle before frame", 96'(out_ctrl), 96'hFF);
    check(out_ctrl == 8'h01 && out_data == START_W, "R3 start word",
          {out_ctrl, 24'd0, out_data}, {8'h01, 24'd0, START_W});
    for (int k = 0; k < NPAY + 2; k++) begin
      @(negedge out_clk);
      w[k] = out_data;
      if (out_ctrl != 8'h00) bad_ctrl = 1;
    end
    check(!bad_ctrl, "R3 body control", 96'(bad_ctrl), 96'd0);
    check(w[0][63:48] == exp_fcnt, "R4 frame counter", 96'(w[0][63:48]), 96'(exp_fcnt));
    check(w[0][47:0] == (has_vc ? {16'd4, vcd} : 48'd0), "R5 channel slot",
          96'(w[0][47:0]), 96'(has_vc ? {16'd4, vcd} : 48'd0));
    for (int g = 0; g < GROUPS; g++) begin
      a = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      b = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      ep[3*g]   = a[63:0];
      ep[3*g+1] = {b[31:0], a[95:64]};
      ep[3*g+2] = b[95:32];
    end
    for (int k = 0; k < NPAY; k++)
      if (w[k+1] != ep[k] && !bad_pay) begin bad_pay = 1; bad_k = k; end
    check(!bad_pay, "R6 payload regroup", 96'(w[bad_k+1]), 96'(ep[bad_k]));
    crc = 32'hFFFFFFFF;
    for (int k = 0; k <= NPAY; k++) crc = crc_ref(crc, w[k]);
    check(w[NPAY+1] == {32'd0, ~crc}, "R7 frame CRC", 96'(w[NPAY+1]), 96'({32'd0, ~crc}));
    @(negedge out_clk);
    check(out_ctrl == 8'hFF, "R2 idle after frame", 96'(out_ctrl), 96'hFF);
    exp_fcnt++;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (12) @(negedge out_clk);
    // R1: idle while reset is held
    check(out_ctrl == 8'hFF && out_data == IDLE_W, "R1 idle in reset",
          {out_ctrl, 24'd0, out_data}, {8'hFF, 24'd0, IDLE_W});
    in_rst = 0; out_rst = 0;
    repeat (6) @(negedge out_clk);
    check(out_ctrl == 8'hFF && out_data == IDLE_W, "R1 idle after reset",
          {out_ctrl, 24'd0, out_data}, {8'hFF, 24'd0, IDLE_W});
    check(ovf_err == 1'b0, "R1 overflow flag clear", 96'(ovf_err), 96'd0);

    // table of frame scenarios (R3 R4 R5 R6 R7)
    for (int v = 0; v < 4; v++) begin
      push_words(VECS[v][15:0], NWORDS, 0);
      if (VECS[v][48]) load_mc(VECS[v][47:16]);
      pulse_sync();
      capture_frame(VECS[v][48], VECS[v][47:16]);
    end

    // R8: sync with too little data waits, then starts without a new sync
    push_words(16'h5505, 5, 0);
    pulse_sync();
    idle_window(40, "R8 short payload holds frame");
    push_words(16'h5505, NWORDS - 5, 5);
    capture_frame(1'b0, 32'd0);

    // R8: a full payload with no sync sends nothing
    push_words(16'h6606, NWORDS, 0);
    idle_window(40, "R8 no frame without sync");
    pulse_sync();
    capture_frame(1'b0, 32'd0);

    // R9: overflow drops extra words, keeps stored ones, flag is sticky
    check(ovf_err == 1'b0, "R9 flag clear before overflow", 96'(ovf_err), 96'd0);
    push_words(16'h7707, 20, 0);
    @(negedge in_clk);
    check(ovf_err == 1'b1, "R9 flag set on overflow", 96'(ovf_err), 96'd1);
    pulse_sync();
    capture_frame(1'b0, 32'd0);
    pulse_sync();
    capture_frame(1'b0, 32'd0);
    idle_window(30, "R9 dropped words never sent");
    @(negedge in_clk);
    check(ovf_err == 1'b1, "R9 flag sticky", 96'(ovf_err), 96'd1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule